// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the instruction address of a small accumulator-style controller and keeps the return addresses of nested subroutine calls. Each cycle it can move to the next address, jump to a subroutine, or return from one. The address is 13 bits wide. A call instruction carries only an 11-bit target, so the two upper address bits come from a page register. Software writes that register on its own, before the call.

A call saves the address that follows the current one on an eight-entry circular stack. It then loads the new address, and the cycle after it is an empty slot, which gives the call its two-cycle cost. A return restores the full saved address and pops the stack. The top of the stack is always visible on an output.

Top module: `paged_pc_stack`

## Requirements
- R1: After reset, `pc_o` is 0x0000 and `tos_o` is 0x0000.
- R2: When `step_en` is the only operation requested in a usable cycle, `pc_o` rises by one on the next edge and wraps from 0x1FFF to 0x0000.
- R3: An accepted call sets `pc_o[10:0]` to `call_target` and `pc_o[12:11]` to bits 4:3 of the page register. The page register takes `page_wdata` on every edge where `page_wr` is high. A call issued in the same cycle as a page write uses the previous page value.
- R4: An accepted call pushes the old `pc_o` plus one, and this value appears on `tos_o` after the same edge.
- R5: The cycle after an accepted call is an empty slot. In it, `call_req`, `ret_req` and `step_en` are ignored and `pc_o` holds.
- R6: An accepted return loads all 13 bits of `tos_o` into `pc_o`, ignoring the page register, and pops the stack.
- R7: The stack holds eight return addresses, and nested returns come back in last-in, first-out order.
- R8: A ninth push overwrites the oldest entry without any indication. After nine pushes, nine returns yield the newest eight in reverse order and then the newest again.
- R9: When several requests arrive in one usable cycle, a call wins over a return, and a return wins over an increment.
- R10: With no request, `pc_o` and `tos_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance to the next address |
| call_req | input | 1 | Call request |
| call_target | input | 11 | Low address bits of the call target |
| page_wr | input | 1 | Write enable for the page register |
| page_wdata | input | 8 | Page register data; bits 4:3 select the page |
| ret_req | input | 1 | Return request |
| pc_o | output | 13 | Current program counter |
| tos_o | output | 13 | Top of the return stack |

## Verification
The hardest state to reach is the stack after it has wrapped, because only a ninth unbroken level of nesting overwrites the oldest entry. The stimulus runs nine calls back to back, each followed by its empty slot. It then runs nine returns, so the eighth pop lands on the overwritten slot and the ninth pop wraps onto the newest address again. The empty slot after a call is also loaded with every request set, to show that none of them takes effect.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_CALL = 2'd2,
        OP_RET  = 2'd3
    } pc_op_e;
endpackage

// File: rtl/pcs_op_decode.sv
module pcs_op_decode
    import pcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_en,
    input  logic   call_req,
    input  logic   ret_req,
    output pc_op_e op,
    output logic   slot_dead
);
    typedef struct packed {
        logic dead;
    } dec_state_t;

    dec_state_t st_d, st_q;
    pc_op_e     op_w;

    always_comb begin
        st_d = st_q;
        op_w = OP_HOLD;
        if (st_q.dead) begin
            st_d.dead = 1'b0;
        end else if (call_req) begin
            op_w      = OP_CALL;
            st_d.dead = 1'b1;
        end else if (ret_req) begin
            op_w = OP_RET;
        end else if (step_en) begin
            op_w = OP_STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign op        = op_w;
    assign slot_dead = st_q.dead;
endmodule

// File: rtl/pcs_page_latch.sv
module pcs_page_latch #(
    parameter int REG_W   = 8,
    parameter int SEL_LO  = 3,
    parameter int SEL_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [SEL_W-1:0] page_bits
);
    typedef struct packed {
        logic [REG_W-1:0] value;
    } page_state_t;

    page_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.value = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign page_bits = st_q.value[SEL_LO +: SEL_W];
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int ADDR_W = 13,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_val,
    output logic [ADDR_W-1:0] top_val
);
    localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] mem;
        logic [SP_W-1:0]              sp;
    } stk_state_t;

    stk_state_t      st_d, st_q;
    logic [SP_W-1:0] top_idx;

    assign top_idx = SP_W'(st_q.sp - 1'b1);

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.sp] = push_val;
            st_d.sp           = SP_W'(st_q.sp + 1'b1);
        end else if (pop) begin
            st_d.sp = top_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top_val = st_q.mem[top_idx];
endmodule

// File: rtl/pcs_pc_reg.sv
module pcs_pc_reg
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int IMM_W  = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  pc_op_e                   op,
    input  logic [IMM_W-1:0]         target,
    input  logic [ADDR_W-IMM_W-1:0]  page_bits,
    input  logic [ADDR_W-1:0]        ret_addr,
    output logic [ADDR_W-1:0]        pc,
    output logic [ADDR_W-1:0]        pc_next_seq
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t         st_d, st_q;
    logic [ADDR_W-1:0] seq_w;

    assign seq_w = ADDR_W'(st_q.pc + 1'b1);

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_STEP: st_d.pc = seq_w;
            OP_CALL: st_d.pc = {page_bits, target};
            OP_RET:  st_d.pc = ret_addr;
            default: st_d.pc = st_q.pc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc          = st_q.pc;
    assign pc_next_seq = seq_w;
endmodule

// File: rtl/paged_pc_stack.sv
module paged_pc_stack
    import pcs_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int IMM_W   = 11,
    parameter int DEPTH   = 8,
    parameter int PAGE_W  = 8,
    parameter int PAGE_LO = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              call_req,
    input  logic [IMM_W-1:0]  call_target,
    input  logic              page_wr,
    input  logic [PAGE_W-1:0] page_wdata,
    input  logic              ret_req,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] tos_o
);
    localparam int HI_W = ADDR_W - IMM_W;

    pc_op_e            op_w;
    logic              dead_w;
    logic [HI_W-1:0]   page_w;
    logic [ADDR_W-1:0] link_w;
    logic [ADDR_W-1:0] top_w;

    pcs_op_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .call_req  (call_req),
        .ret_req   (ret_req),
        .op        (op_w),
        .slot_dead (dead_w)
    );

    pcs_page_latch #(.REG_W(PAGE_W), .SEL_LO(PAGE_LO), .SEL_W(HI_W)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (page_wr),
        .wr_data   (page_wdata),
        .page_bits (page_w)
    );

    pcs_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (op_w == OP_CALL),
        .pop      (op_w == OP_RET),
        .push_val (link_w),
        .top_val  (top_w)
    );

    pcs_pc_reg #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op_w),
        .target      (call_target),
        .page_bits   (page_w),
        .ret_addr    (top_w),
        .pc          (pc_o),
        .pc_next_seq (link_w)
    );

    assign tos_o = top_w;
endmodule

// File: rtl/paged_pc_stack_chk.sv
module paged_pc_stack_chk #(
    parameter int ADDR_W = 13,
    parameter int IMM_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic              call_req,
    input logic [IMM_W-1:0]  call_target,
    input logic              ret_req,
    input logic              dead,
    input logic [ADDR_W-IMM_W-1:0] page_sel,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] tos_o
);
    logic call_ok, ret_ok, step_ok, idle_ok;
    assign call_ok = call_req && !dead;
    assign ret_ok  = ret_req && !call_req && !dead;
    assign step_ok = step_en && !ret_req && !call_req && !dead;
    assign idle_ok = !step_en && !ret_req && !call_req && !dead;

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

    assert_call_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        call_ok |=> pc_o[IMM_W-1:0] == $past(call_target));

    assert_call_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        call_ok |=> pc_o[ADDR_W-1:IMM_W] == $past(page_sel));

    assert_push_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
        call_ok |=> tos_o == ADDR_W'($past(pc_o) + 1'b1));

    assert_dead_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dead |=> ($stable(pc_o) && $stable(tos_o)));

    assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ok |=> pc_o == $past(tos_o));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ok |=> ($stable(pc_o) && $stable(tos_o)));
endmodule

bind paged_pc_stack paged_pc_stack_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_en     (step_en),
    .call_req    (call_req),
    .call_target (call_target),
    .ret_req     (ret_req),
    .dead        (dead_w),
    .page_sel    (page_w),
    .pc_o        (pc_o),
    .tos_o       (tos_o)
);

// File: tb/paged_pc_stack_test.sv
module paged_pc_stack_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0, call_req = 1'b0, page_wr = 1'b0, ret_req = 1'b0;
    logic [10:0] call_target = '0;
    logic [7:0]  page_wdata = '0;
    logic [12:0] pc_o, tos_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [12:0] pc;
        logic [12:0] tos;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // scoreboard model state, built from the requirements
    logic [12:0] m_pc = '0;
    logic [7:0]  m_page = '0;
    bit          m_dead = 1'b0;
    logic [12:0] m_stk [8];
    int          m_sp = 0;

    always #2 clk = ~clk;

    paged_pc_stack uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .call_req(call_req),
        .call_target(call_target), .page_wr(page_wr), .page_wdata(page_wdata),
        .ret_req(ret_req), .pc_o(pc_o), .tos_o(tos_o)
    );

    function automatic logic [12:0] m_tos();
        return m_stk[(m_sp + 7) % 8];
    endfunction

    task automatic cyc(input bit c, input logic [10:0] t, input bit pw,
                       input logic [7:0] pd, input bit r, input bit s, input string tag);
        exp_t e;
        @(negedge clk);
        call_req = c; call_target = t; page_wr = pw; page_wdata = pd;
        ret_req = r; step_en = s;
        if (m_dead) begin
            m_dead = 1'b0;
        end else if (c) begin
            m_stk[m_sp] = m_pc + 13'd1;
            m_sp = (m_sp + 1) % 8;
            m_pc = {m_page[4:3], t};
            m_dead = 1'b1;
        end else if (r) begin
            m_pc = m_tos();
            m_sp = (m_sp + 7) % 8;
        end else if (s) begin
            m_pc = m_pc + 13'd1;
        end
        if (pw) m_page = pd;
        e.pc = m_pc; e.tos = m_tos(); e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        cyc(0, '0, 0, '0, 0, 0, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (pc_o !== e.pc || tos_o !== e.tos) begin
                    errors++;
                    $display("FAIL %s pc=%h tos=%h expected pc=%h tos=%h",
                             e.tag, pc_o, tos_o, e.pc, e.tos);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (pc_o !== 13'h0 || tos_o !== 13'h0) begin
            errors++;
            $display("FAIL R1 pc=%h tos=%h expected pc=0000 tos=0000", pc_o, tos_o);
        end
        rst_n = 1'b1;

        idle("R10 idle hold");
        cyc(0, '0, 0, '0, 0, 1, "R2 step");
        cyc(0, '0, 0, '0, 0, 1, "R2 step");
        // page write then call on page 3
        cyc(0, '0, 1, 8'h18, 0, 0, "R3 page write");
        cyc(1, 11'h123, 0, '0, 0, 0, "R3 R4 call");
        cyc(1, 11'h555, 0, '0, 1, 1, "R5 dead slot ignored");
        cyc(0, '0, 0, '0, 0, 1, "R2 step after call");
        // page write in same cycle as call uses old page
        cyc(1, 11'h010, 1, 8'h08, 0, 0, "R3 same-cycle write uses old page");
        idle("R5 dead slot");
        // return ignores page register
        cyc(0, '0, 1, 8'h00, 0, 0, "R3 page write");
        cyc(0, '0, 0, '0, 1, 0, "R6 return full address");
        cyc(0, '0, 0, '0, 1, 1, "R6 R9 return over step");
        // wrap test
        cyc(0, '0, 1, 8'h18, 0, 0, "R3 page write");
        cyc(1, 11'h7FF, 0, '0, 1, 1, "R9 call over return");
        idle("R5 dead slot");
        cyc(0, '0, 0, '0, 0, 1, "R2 wrap to 0000");
        cyc(0, '0, 0, '0, 0, 1, "R2 step");
        cyc(0, '0, 0, '0, 1, 0, "R6 return");
        // nine nested calls, then nine returns
        cyc(0, '0, 1, 8'h10, 0, 0, "R3 page write");
        for (int k = 0; k < 9; k++) begin
            cyc(1, 11'(k * 16 + 3), 0, '0, 0, 0, "R7 R8 nested call");
            idle("R5 dead slot");
        end
        for (int k = 0; k < 9; k++) begin
            cyc(0, '0, 0, '0, 1, 0, (k == 8) ? "R8 wrapped pop" : "R7 LIFO return");
        end
        idle("R10 idle hold");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule